// File: doc/BRIEF.md
# Pointer-Indexed Serial Channel Control Port

This block is the control-side register interface of one channel of a serial controller. The CPU reaches eight write registers and three status registers through a single control address. A 3-bit pointer chooses which register the next control access reaches. The pointer is loaded by a write to register 0 and falls back to 0 after any access to another register, so most accesses take two steps: one write that sets the pointer, then the data access.

Register 0 also carries two encoded fields. The block turns them into one-cycle strobes for the rest of the channel:
- a command field, for abort, interrupt clears, channel reset, receive-interrupt re-arm and return from interrupt;
- a reset field, for the CRC and underrun-latch resets.

The block keeps registers 1 to 7 and brings them out to the channel. It emits change pulses when the modem-control bits of register 5 flip. It holds the three status registers, which the serial side loads, and returns the one the pointer selects. The serial shifting logic sits outside this block.

Top module: `ctrl_regport`

## Requirements
- R1: A write while the pointer is 0 stores the whole byte as register 0 and loads the pointer from data bits 2..0 (output `ptr_q`).
- R2: A write while the pointer is k (1..7) stores the byte into register k (byte k of `wregs`, bits 8k+7..8k) and sets the pointer to 0. All write registers are 0 after reset.
- R3: A read while the pointer is nonzero sets the pointer to 0. A read while the pointer is 0 leaves it at 0.
- R4: A register 0 write with command field bits 5..3 = c, for c in 1..6, raises `cmd_stb[c]` for exactly the one cycle after the write. Code 0 raises nothing, and `cmd_stb` is never raised by writes to other registers. Codes: 1 abort, 2 clear ext/status interrupt, 3 channel reset, 4 interrupt on next received character, 5 clear transmit interrupt, 6 error reset, 7 return from interrupt.
- R5: Command code 7 raises `cmd_stb[7]` only when the block is built as channel A (`IS_CHAN_A`=1). Otherwise it raises nothing.
- R6: A register 0 write with reset field bits 7..6 = r, for r in 1..3, raises `rstc_stb[r]` for one cycle. The codes are 1 receive CRC, 2 transmit CRC, 3 transmit underrun latch. Code 0 raises nothing.
- R7: Channel reset (code 3) and block reset both leave status register 0 at 8'h04 (transmit buffer empty only) and status registers 1 and 2 at 0. The channel reset command also pulses all four bits of `int_clr` in the cycle after the write.
- R8: `int_clr` bit 0 is the transmit source, bit 1 ext/status, bit 2 receive, bit 3 error. Command 5 pulses bit 0, command 2 pulses bit 1 and command 6 pulses bit 3. Command 4 pulses no bit.
- R9: A write to register 5 pulses `dtr_chg`, `brk_chg` or `rts_chg` for one cycle when it changes bit 7, bit 4 or bit 1 of that register respectively. Changes to other bits pulse nothing.
- R10: A read returns, in `rd_data` one cycle later, status register p for p in 0..2 and 8'h00 for p in 3..7. `rd_data` holds its value when no read happens.
- R11: In a read of status register 0, bit 1 is replaced by `irq_any` on channel A and by 0 on channel B. The stored bit 1 is not used.
- R12: `sts_wr` loads `sts_data` into status register `sts_sel` (0..2), and values of `sts_sel` of 3 or more are ignored. A channel reset command in the same cycle wins.
- R13: A read and a write in the same cycle perform only the write. The pointer follows the write rules and `rd_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU control write strobe |
| rd_en | input | 1 | CPU control read strobe |
| wr_data | input | 8 | CPU write data |
| irq_any | input | 1 | Device-wide interrupt pending |
| sts_wr | input | 1 | Status load strobe from serial side |
| sts_sel | input | 2 | Status register to load |
| sts_data | input | 8 | Status load value |
| ptr_q | output | 3 | Current register pointer |
| wregs | output | 64 | Write registers, byte k = register k |
| rd_data | output | 8 | Registered read data |
| cmd_stb | output | 8 | Command strobes, bit c = command code c |
| rstc_stb | output | 4 | Reset-field strobes, bit r = reset code r |
| int_clr | output | 4 | Interrupt source clear pulses |
| dtr_chg | output | 1 | Register 5 bit 7 changed |
| brk_chg | output | 1 | Register 5 bit 4 changed |
| rts_chg | output | 1 | Register 5 bit 1 changed |

## Verification
The bench builds two copies with identical stimulus, one with `IS_CHAN_A`=1 and one with `IS_CHAN_A`=0, and keeps the default of eight write registers and three status registers. The paired build brings the channel-only behaviour within reach. The return-from-interrupt strobe and the replaced interrupt-pending bit can then be compared directly across the two channels in the same cycle. Eight registers put the full 3-bit pointer range under test, including the reads above the status registers that must return zero.

// File: rtl/ctrlport_pkg.sv
package ctrlport_pkg;

    localparam int BYTE_W  = 8;
    localparam int N_WREG  = 8;
    localparam int PTR_W   = $clog2(N_WREG);
    localparam int N_STAT  = 3;
    localparam int SSEL_W  = $clog2(N_STAT);
    localparam int N_INT   = 4;
    localparam int N_CMD   = 8;
    localparam int N_RSTC  = 4;

    // interrupt source positions in int_clr
    localparam int INT_TX  = 0;
    localparam int INT_EXT = 1;
    localparam int INT_RX  = 2;
    localparam int INT_ERR = 3;

    // status register 0 bit positions
    localparam int SR0_TXE = 2;
    localparam int SR0_IRQ = 1;

    localparam logic [BYTE_W-1:0] SR0_RESET_VAL = BYTE_W'(1 << SR0_TXE);

    // register 5 modem bit positions
    localparam int W5_DTR  = 7;
    localparam int W5_BRK  = 4;
    localparam int W5_RTS  = 1;
    localparam int MODEM_REG = 5;

    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_ABORT    = 3'd1,
        CMD_EXT_CLR  = 3'd2,
        CMD_CHAN_RST = 3'd3,
        CMD_RX_NEXT  = 3'd4,
        CMD_TX_CLR   = 3'd5,
        CMD_ERR_CLR  = 3'd6,
        CMD_RETI     = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        RSTC_NOP      = 2'd0,
        RSTC_RX_CRC   = 2'd1,
        RSTC_TX_CRC   = 2'd2,
        RSTC_TX_LATCH = 2'd3
    } rstc_e;

    typedef struct packed {
        logic dtr;
        logic brk;
        logic rts;
    } modem_t;

    function automatic modem_t pick_modem(input logic [BYTE_W-1:0] b);
        modem_t m;
        m.dtr = b[W5_DTR];
        m.brk = b[W5_BRK];
        m.rts = b[W5_RTS];
        return m;
    endfunction

    function automatic logic [N_INT-1:0] int_clear_map(input cmd_e c);
        logic [N_INT-1:0] v;
        v = '0;
        case (c)
            CMD_CHAN_RST: v = '1;
            CMD_EXT_CLR:  v[INT_EXT] = 1'b1;
            CMD_TX_CLR:   v[INT_TX]  = 1'b1;
            CMD_ERR_CLR:  v[INT_ERR] = 1'b1;
            default:      v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ctrl_wreg_file.sv
module ctrl_wreg_file
    import ctrlport_pkg::*;
#(
    parameter int NREG = N_WREG,
    parameter int DW   = BYTE_W,
    localparam int PW  = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [DW-1:0]       wr_data,
    output logic [PW-1:0]       ptr_q,
    output logic [NREG-1:0]     sel_wr,
    output logic [NREG*DW-1:0]  regs_flat
);

    logic [NREG-1:0][DW-1:0] regs;

    always_comb begin
        sel_wr = '0;
        if (wr_en)
            sel_wr[ptr_q] = 1'b1;
    end

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[k] <= '0;
            else if (sel_wr[k])
                regs[k] <= wr_data;
        end
        assign regs_flat[k*DW +: DW] = regs[k];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (wr_en)
            ptr_q <= (ptr_q == '0) ? wr_data[PW-1:0] : '0;
        else if (rd_en && ptr_q != '0)
            ptr_q <= '0;
    end

    assert_ptr_load_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ptr_q == '0) |=> ptr_q == $past(wr_data[PW-1:0]));

    assert_ptr_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ptr_q != '0) |=> ptr_q == '0);

    assert_store_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ptr_q != '0) |=> regs[$past(ptr_q)] == $past(wr_data));

    assert_rd_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> ptr_q == '0);

endmodule

// File: rtl/ctrl_cmd_decode.sv
module ctrl_cmd_decode
    import ctrlport_pkg::*;
#(
    parameter bit IS_CHAN_A = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr0_hit,
    input  logic [2:0]        cmd_field,
    input  logic [1:0]        rstc_field,
    output logic              chan_rst_now,
    output logic [N_CMD-1:0]  cmd_stb,
    output logic [N_RSTC-1:0] rstc_stb,
    output logic [N_INT-1:0]  int_clr
);

    cmd_e  cmd;
    rstc_e rstc;
    logic  cmd_ok;

    always_comb begin
        cmd    = cmd_e'(cmd_field);
        rstc   = rstc_e'(rstc_field);
        cmd_ok = wr0_hit && cmd != CMD_NOP && (cmd != CMD_RETI || IS_CHAN_A);
        chan_rst_now = wr0_hit && cmd == CMD_CHAN_RST;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_stb  <= '0;
            rstc_stb <= '0;
            int_clr  <= '0;
        end else begin
            cmd_stb  <= '0;
            rstc_stb <= '0;
            int_clr  <= '0;
            if (cmd_ok)
                cmd_stb[cmd] <= 1'b1;
            if (wr0_hit && rstc != RSTC_NOP)
                rstc_stb[rstc] <= 1'b1;
            if (wr0_hit)
                int_clr <= int_clear_map(cmd);
        end
    end

    assert_cmd_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_stb) && !cmd_stb[0]);

    assert_cmd_src_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb != '0) |-> $past(wr0_hit));

    assert_rstc_src_R6: assert property (@(posedge clk) disable iff (rst)
        (rstc_stb != '0) |-> ($past(wr0_hit) && $onehot(rstc_stb)));

    assert_reset_clears_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_stb[CMD_CHAN_RST] |-> int_clr == '1);

    assert_reti_chan_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_stb[CMD_RETI] |-> ($past(cmd_field) == 3'd7 && IS_CHAN_A));

endmodule

// File: rtl/ctrl_status_regs.sv
module ctrl_status_regs
    import ctrlport_pkg::*;
#(
    parameter bit IS_CHAN_A = 1'b1,
    parameter int NSTAT = N_STAT,
    parameter int DW    = BYTE_W,
    parameter int PW    = PTR_W,
    localparam int SW   = $clog2(NSTAT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chan_rst_now,
    input  logic          sts_wr,
    input  logic [SW-1:0] sts_sel,
    input  logic [DW-1:0] sts_data,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [PW-1:0] ptr,
    input  logic          irq_any,
    output logic [DW-1:0] rd_data
);

    logic [NSTAT-1:0][DW-1:0] sr;
    logic [DW-1:0]            view;

    for (genvar k = 0; k < NSTAT; k++) begin : g_sr
        localparam logic [DW-1:0] INIT = (k == 0) ? SR0_RESET_VAL : '0;
        always_ff @(posedge clk) begin
            if (rst || chan_rst_now)
                sr[k] <= INIT;
            else if (sts_wr && int'(sts_sel) == k)
                sr[k] <= sts_data;
        end
    end

    always_comb begin
        view = '0;
        if (int'(ptr) < NSTAT)
            view = sr[ptr];
        if (ptr == '0)
            view[SR0_IRQ] = IS_CHAN_A ? irq_any : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en && !wr_en)
            rd_data <= view;
    end

    assert_chan_reset_R7: assert property (@(posedge clk) disable iff (rst)
        chan_rst_now |=> (sr[0] == SR0_RESET_VAL && sr[1] == '0 && sr[2] == '0));

    assert_irq_bit_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && ptr == '0) |=>
            rd_data[SR0_IRQ] == (IS_CHAN_A ? $past(irq_any) : 1'b0));

    assert_sts_load_R12: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && !chan_rst_now && sts_sel == SW'(1)) |=> sr[1] == $past(sts_data));

    assert_collide_R13: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> $stable(rd_data));

    assert_high_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && int'(ptr) >= NSTAT) |=> rd_data == '0);

endmodule

// File: rtl/ctrl_modem_watch.sv
module ctrl_modem_watch
    import ctrlport_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr5_hit,
    input  modem_t new_bits,
    input  modem_t old_bits,
    output logic   dtr_chg,
    output logic   brk_chg,
    output logic   rts_chg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dtr_chg <= 1'b0;
            brk_chg <= 1'b0;
            rts_chg <= 1'b0;
        end else begin
            dtr_chg <= wr5_hit && (new_bits.dtr != old_bits.dtr);
            brk_chg <= wr5_hit && (new_bits.brk != old_bits.brk);
            rts_chg <= wr5_hit && (new_bits.rts != old_bits.rts);
        end
    end

    assert_dtr_src_R9: assert property (@(posedge clk) disable iff (rst)
        dtr_chg |-> $past(wr5_hit));

    assert_brk_src_R9: assert property (@(posedge clk) disable iff (rst)
        brk_chg |-> $past(wr5_hit));

    assert_rts_flip_R9: assert property (@(posedge clk) disable iff (rst)
        (wr5_hit && new_bits.rts != old_bits.rts) |=> rts_chg);

endmodule

// File: rtl/ctrl_regport.sv
module ctrl_regport
    import ctrlport_pkg::*;
#(
    parameter bit IS_CHAN_A = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic                     irq_any,
    input  logic                     sts_wr,
    input  logic [SSEL_W-1:0]        sts_sel,
    input  logic [BYTE_W-1:0]        sts_data,
    output logic [PTR_W-1:0]         ptr_q,
    output logic [N_WREG*BYTE_W-1:0] wregs,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [N_CMD-1:0]         cmd_stb,
    output logic [N_RSTC-1:0]        rstc_stb,
    output logic [N_INT-1:0]         int_clr,
    output logic                     dtr_chg,
    output logic                     brk_chg,
    output logic                     rts_chg
);

    logic [N_WREG-1:0] sel_wr;
    logic              chan_rst_now;
    modem_t            m_new, m_old;

    ctrl_wreg_file #(.NREG(N_WREG), .DW(BYTE_W)) u_file (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_data   (wr_data),
        .ptr_q     (ptr_q),
        .sel_wr    (sel_wr),
        .regs_flat (wregs)
    );

    ctrl_cmd_decode #(.IS_CHAN_A(IS_CHAN_A)) u_cmd (
        .clk          (clk),
        .rst          (rst),
        .wr0_hit      (sel_wr[0]),
        .cmd_field    (wr_data[5:3]),
        .rstc_field   (wr_data[7:6]),
        .chan_rst_now (chan_rst_now),
        .cmd_stb      (cmd_stb),
        .rstc_stb     (rstc_stb),
        .int_clr      (int_clr)
    );

    ctrl_status_regs #(.IS_CHAN_A(IS_CHAN_A), .NSTAT(N_STAT), .DW(BYTE_W), .PW(PTR_W)) u_sts (
        .clk          (clk),
        .rst          (rst),
        .chan_rst_now (chan_rst_now),
        .sts_wr       (sts_wr),
        .sts_sel      (sts_sel),
        .sts_data     (sts_data),
        .rd_en        (rd_en),
        .wr_en        (wr_en),
        .ptr          (ptr_q),
        .irq_any      (irq_any),
        .rd_data      (rd_data)
    );

    always_comb begin
        m_new = pick_modem(wr_data);
        m_old = pick_modem(wregs[MODEM_REG*BYTE_W +: BYTE_W]);
    end

    ctrl_modem_watch u_modem (
        .clk      (clk),
        .rst      (rst),
        .wr5_hit  (sel_wr[MODEM_REG]),
        .new_bits (m_new),
        .old_bits (m_old),
        .dtr_chg  (dtr_chg),
        .brk_chg  (brk_chg),
        .rts_chg  (rts_chg)
    );

endmodule

// File: tb/sim_ctrl_regport.sv
module sim_ctrl_regport;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, irq_any = 1'b0, sts_wr = 1'b0;
    logic [7:0]  wr_data = '0, sts_data = '0;
    logic [1:0]  sts_sel = '0;

    logic [2:0]  ptr_a, ptr_b;
    logic [63:0] wregs_a, wregs_b;
    logic [7:0]  rd_a, rd_b, cmd_a, cmd_b;
    logic [3:0]  rstc_a, rstc_b, iclr_a, iclr_b;
    logic        dtr_a, brk_a, rts_a, dtr_b, brk_b, rts_b;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    ctrl_regport #(.IS_CHAN_A(1'b1)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
        .irq_any(irq_any), .sts_wr(sts_wr), .sts_sel(sts_sel), .sts_data(sts_data),
        .ptr_q(ptr_a), .wregs(wregs_a), .rd_data(rd_a), .cmd_stb(cmd_a),
        .rstc_stb(rstc_a), .int_clr(iclr_a), .dtr_chg(dtr_a), .brk_chg(brk_a), .rts_chg(rts_a));

    ctrl_regport #(.IS_CHAN_A(1'b0)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
        .irq_any(irq_any), .sts_wr(sts_wr), .sts_sel(sts_sel), .sts_data(sts_data),
        .ptr_q(ptr_b), .wregs(wregs_b), .rd_data(rd_b), .cmd_stb(cmd_b),
        .rstc_stb(rstc_b), .int_clr(iclr_b), .dtr_chg(dtr_b), .brk_chg(brk_b), .rts_chg(rts_b));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock of stimulus; returns just after the edge
    task automatic cyc(input logic w, input logic r, input logic [7:0] d,
                       input logic sw, input logic [1:0] ss, input logic [7:0] sd);
        @(negedge clk);
        wr_en = w; rd_en = r; wr_data = d; sts_wr = sw; sts_sel = ss; sts_data = sd;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; sts_wr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);  cyc(1'b1, 1'b0, d, 1'b0, 2'd0, 8'h00); endtask
    task automatic rd();                     cyc(1'b0, 1'b1, 8'h00, 1'b0, 2'd0, 8'h00); endtask
    task automatic idle();                   cyc(1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 8'h00); endtask
    task automatic sload(input logic [1:0] s, input logic [7:0] d);
        cyc(1'b0, 1'b0, 8'h00, 1'b1, s, d);
    endtask
    task automatic rd_reg(input logic [2:0] p);
        if (p != 3'd0) wr({5'b00000, p});
        rd();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R2 reset ptr", 64'(ptr_a), 64'd0);
        check("R2 reset wregs", wregs_a, 64'd0);
        rd();
        check("R7 reset sr0", 64'(rd_a), 64'h04);
    endtask

    task automatic t_pointer();
        wr(8'h06);
        check("R1 ptr load", 64'(ptr_a), 64'd6);
        wr(8'h3C);
        check("R2 reg6 store", 64'(wregs_a[55:48]), 64'h3C);
        check("R2 ptr back", 64'(ptr_a), 64'd0);
        check("R1 reg0 byte", 64'(wregs_a[7:0]), 64'h06);
        wr(8'h07); wr(8'hE1);
        check("R2 reg7 store", 64'(wregs_a[63:56]), 64'hE1);
        wr(8'h01); wr(8'h9B);
        check("R2 reg1 store", 64'(wregs_a[15:8]), 64'h9B);
    endtask

    task automatic t_readptr();
        wr(8'h02);
        rd();
        check("R3 read clears ptr", 64'(ptr_a), 64'd0);
        rd();
        check("R3 read at 0 keeps ptr", 64'(ptr_a), 64'd0);
    endtask

    task automatic t_cmds();
        for (int c = 1; c <= 6; c++) begin
            wr(8'(c << 3));
            check($sformatf("R4 cmd %0d strobe", c), 64'(cmd_a), 64'(1 << c));
            idle();
            check($sformatf("R4 cmd %0d one cycle", c), 64'(cmd_a), 64'd0);
        end
        wr(8'h00);
        check("R4 null cmd", 64'(cmd_a), 64'd0);
        wr(8'h01);
        wr(8'h18);
        check("R4 no cmd from reg1 write", 64'(cmd_a), 64'd0);
        check("R4 reg1 write no int clear", 64'(iclr_a), 64'd0);
    endtask

    task automatic t_reti();
        wr(8'h38);
        check("R5 reti on channel A", 64'(cmd_a), 64'h80);
        check("R5 no reti on channel B", 64'(cmd_b), 64'h00);
    endtask

    task automatic t_rstfield();
        wr(8'h40); check("R6 rx crc", 64'(rstc_a), 64'h2);
        wr(8'h80); check("R6 tx crc", 64'(rstc_a), 64'h4);
        wr(8'hC0); check("R6 tx latch", 64'(rstc_a), 64'h8);
        wr(8'h00); check("R6 null", 64'(rstc_a), 64'h0);
    endtask

    task automatic t_chanrst();
        sload(2'd0, 8'hFF); sload(2'd1, 8'h5A); sload(2'd2, 8'h33);
        wr(8'h18);
        check("R7 int_clr all", 64'(iclr_a), 64'hF);
        rd();
        check("R7 sr0 after reset", 64'(rd_a), 64'h04);
        rd_reg(3'd1);
        check("R7 sr1 cleared", 64'(rd_a), 64'h00);
        rd_reg(3'd2);
        check("R7 sr2 cleared", 64'(rd_a), 64'h00);
    endtask

    task automatic t_intclr();
        wr(8'h10); check("R8 ext clear", 64'(iclr_a), 64'h2);
        wr(8'h28); check("R8 tx clear", 64'(iclr_a), 64'h1);
        wr(8'h30); check("R8 err clear", 64'(iclr_a), 64'h8);
        wr(8'h20);
        check("R8 rx next no clear", 64'(iclr_a), 64'h0);
        check("R4 rx next strobe", 64'(cmd_a), 64'h10);
    endtask

    task automatic t_modem();
        wr(8'h05); wr(8'h80);
        check("R9 dtr only", 64'({dtr_a, brk_a, rts_a}), 64'b100);
        idle();
        check("R9 pulse one cycle", 64'({dtr_a, brk_a, rts_a}), 64'b000);
        wr(8'h05); wr(8'h92);
        check("R9 brk rts", 64'({dtr_a, brk_a, rts_a}), 64'b011);
        wr(8'h05); wr(8'h92);
        check("R9 same value none", 64'({dtr_a, brk_a, rts_a}), 64'b000);
        wr(8'h05); wr(8'h00);
        check("R9 all three", 64'({dtr_a, brk_a, rts_a}), 64'b111);
        wr(8'h05); wr(8'h6D);
        check("R9 other bits none", 64'({dtr_a, brk_a, rts_a}), 64'b000);
    endtask

    task automatic t_readmux();
        sload(2'd1, 8'hA7);
        for (int p = 3; p <= 7; p++) begin
            rd_reg(3'(p));
            check($sformatf("R10 read ptr %0d", p), 64'(rd_a), 64'h00);
        end
        rd_reg(3'd1);
        check("R10 sr1 read", 64'(rd_a), 64'hA7);
        idle(); idle();
        check("R10 rd_data holds", 64'(rd_a), 64'hA7);
    endtask

    task automatic t_irqbit();
        sload(2'd0, 8'h02);
        irq_any = 1'b0; rd();
        check("R11 A stored bit ignored", 64'(rd_a), 64'h00);
        check("R11 B stored bit ignored", 64'(rd_b), 64'h00);
        sload(2'd0, 8'h05);
        irq_any = 1'b1; rd();
        check("R11 A irq shown", 64'(rd_a), 64'h07);
        check("R11 B irq hidden", 64'(rd_b), 64'h05);
        irq_any = 1'b0;
    endtask

    task automatic t_stsload();
        sload(2'd2, 8'h6C);
        sload(2'd3, 8'hFF);
        rd_reg(3'd2);
        check("R12 sel 3 ignored sr2", 64'(rd_a), 64'h6C);
        rd();
        check("R12 sel 3 ignored sr0", 64'(rd_a), 64'h05);
        cyc(1'b1, 1'b0, 8'h18, 1'b1, 2'd1, 8'hFF);
        rd_reg(3'd1);
        check("R12 reset wins over load", 64'(rd_a), 64'h00);
    endtask

    task automatic t_collide();
        rd();
        check("R13 pre read", 64'(rd_a), 64'h04);
        sload(2'd0, 8'h81);
        cyc(1'b1, 1'b1, 8'h03, 1'b0, 2'd0, 8'h00);
        check("R13 ptr follows write", 64'(ptr_a), 64'd3);
        check("R13 rd_data holds", 64'(rd_a), 64'h04);
        cyc(1'b1, 1'b1, 8'h44, 1'b0, 2'd0, 8'h00);
        check("R13 reg3 written", 64'(wregs_a[31:24]), 64'h44);
        check("R13 ptr cleared", 64'(ptr_a), 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_pointer();
        t_readptr();
        t_cmds();
        t_reti();
        t_rstfield();
        t_chanrst();
        t_intclr();
        t_modem();
        t_readmux();
        t_irqbit();
        t_stsload();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule